// File: doc/BRIEF.md
# Two-Level Page Walker

This block translates a 15-bit virtual address to a 12-bit physical address by walking a two-level page table, then returns the byte stored at that physical address. The page tables and the data share one byte-wide memory inside the block. The memory is split into 32-byte pages and has a single read port with one cycle of read latency. Software or a test harness fills the memory through a plain load port before walks begin, and may keep writing while walks run.

A request carries the virtual address and the page number of the page directory. It enters on a valid/ready channel. `req_ready` is high only while the walker is idle, so a request offered at any other time waits until the current walk has finished and its result has been taken. The result leaves on a valid/ready channel. `rsp_valid` stays high and every result field stays still until the consumer raises `rsp_ready`, so a slow consumer stalls the walker without losing data.

Each walk makes one memory read per level. It reads the directory byte, then the table byte, then the data byte. A cleared valid bit at either level ends the walk early with a fault code that names the level.

Top module: `pw_walker`

## Requirements
- R1: The virtual address splits as bits 14..10 = directory index, bits 9..5 = table index, bits 4..0 = byte offset. On success `rsp_pa` = {frame number, offset}, with the frame number in bits 11..5.
- R2: The directory byte is read at physical address base*32 + directory index. Bit 7 of that byte is its valid flag, and bits 6..0 give the page that holds the table. The table byte is read at that page*32 + table index.
- R3: If the directory byte has bit 7 clear, the response carries `rsp_fault` = 2'b01.
- R4: If the table byte has bit 7 clear, the response carries `rsp_fault` = 2'b10. Every faulted response has `rsp_data` = 0 and `rsp_pa` = 0.
- R5: On a successful walk, `rsp_fault` = 2'b00 and `rsp_data` is the byte at physical address table-byte[6:0]*32 + offset.
- R6: `req_ready` is high only while idle, and a request is accepted only on an edge where `req_valid` and `req_ready` are both high. `req_base` and `req_va` are sampled at that edge, so later changes to them do not affect the walk.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_fault`, `rsp_data` and `rsp_pa` all hold their values. A handshake edge returns the walker to idle.
- R8: A load write (`ld_en`, `ld_addr`, `ld_data`) lands in memory at the clock edge. A walk read of the same address on that same edge returns the old byte, and later reads return the new byte.
- R9: After reset, `req_ready` = 1 and `rsp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 15 | Virtual address to translate |
| req_base | input | 7 | Page number of the page directory |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 2 | 00 ok, 01 directory invalid, 10 table invalid |
| rsp_data | output | 8 | Byte at the translated address (0 on fault) |
| rsp_pa | output | 12 | Translated physical address (0 on fault) |
| ld_en | input | 1 | Write one memory byte |
| ld_addr | input | 12 | Physical address to write |
| ld_data | input | 8 | Byte to write |

## Verification
A load write and a walk read can hit the same memory byte on the same edge. The bench forces this collision. It starts a walk, counts edges from acceptance to the one where the data byte is read (the third edge, counting acceptance as the first), and writes the inverted byte to that address on exactly that edge. The walk must return the old byte. A repeat walk to the same address must return the new one. Result hold under back-pressure is judged by stalling `rsp_ready` for several cycles and comparing each sampled value with the first.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PDE  = 3'd1,
    ST_PTE  = 3'd2,
    ST_DATA = 3'd3,
    ST_DONE = 3'd4
  } walk_st_t;

  localparam logic [1:0] FLT_NONE = 2'b00;
  localparam logic [1:0] FLT_DIR  = 2'b01;
  localparam logic [1:0] FLT_TBL  = 2'b10;
endpackage

// File: rtl/pw_mem.sv
module pw_mem #(
  parameter int AW = 12,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);
  logic [DW-1:0] store [DEPTH];

  // read returns the byte held before any write on the same edge
  always_ff @(posedge clk) begin
    if (we) store[wa] <= wd;
    rq <= store[ra];
  end
endmodule

// File: rtl/pw_addr.sv
module pw_addr
  import pw_pkg::*;
#(
  parameter int OFF_W = 5,
  parameter int PFN_W = 7,
  localparam int VA_W = 3 * OFF_W,
  localparam int PA_W = PFN_W + OFF_W,
  localparam int EW   = PFN_W + 1
) (
  input  walk_st_t         state,
  input  logic [VA_W-1:0]  req_va,
  input  logic [PFN_W-1:0] req_base,
  input  logic [VA_W-1:0]  va_q,
  input  logic [EW-1:0]    rq,
  output logic [PA_W-1:0]  rd_addr
);
  logic [OFF_W-1:0] dir_idx_in;
  logic [OFF_W-1:0] tbl_idx_q;
  logic [OFF_W-1:0] off_q;
  logic [PFN_W-1:0] ptr;

  assign dir_idx_in = req_va[VA_W-1 -: OFF_W];
  assign tbl_idx_q  = va_q[2*OFF_W-1 -: OFF_W];
  assign off_q      = va_q[OFF_W-1:0];
  assign ptr        = rq[PFN_W-1:0];

  always_comb begin
    unique case (state)
      ST_IDLE: rd_addr = {req_base, dir_idx_in};
      ST_PDE:  rd_addr = {ptr, tbl_idx_q};
      ST_PTE:  rd_addr = {ptr, off_q};
      default: rd_addr = '0;
    endcase
  end
endmodule

// File: rtl/pw_fsm.sv
module pw_fsm
  import pw_pkg::*;
#(
  parameter int OFF_W = 5,
  parameter int PFN_W = 7,
  localparam int VA_W = 3 * OFF_W,
  localparam int PA_W = PFN_W + OFF_W,
  localparam int EW   = PFN_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_va,
  input  logic            rsp_ready,
  input  logic [EW-1:0]   rq,
  output walk_st_t        state,
  output logic [VA_W-1:0] va_q,
  output logic [1:0]      fault_q,
  output logic [EW-1:0]   data_q,
  output logic [PA_W-1:0] pa_q
);
  logic ent_valid;
  assign ent_valid = rq[EW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      va_q    <= '0;
      fault_q <= FLT_NONE;
      data_q  <= '0;
      pa_q    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q    <= req_va;
            fault_q <= FLT_NONE;
            data_q  <= '0;
            pa_q    <= '0;
            state   <= ST_PDE;
          end
        end
        ST_PDE: begin
          if (!ent_valid) begin
            fault_q <= FLT_DIR;
            state   <= ST_DONE;
          end else begin
            state <= ST_PTE;
          end
        end
        ST_PTE: begin
          if (!ent_valid) begin
            fault_q <= FLT_TBL;
            state   <= ST_DONE;
          end else begin
            pa_q  <= {rq[PFN_W-1:0], va_q[OFF_W-1:0]};
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          data_q <= rq;
          state  <= ST_DONE;
        end
        ST_DONE: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pw_walker.sv
module pw_walker
  import pw_pkg::*;
#(
  parameter int OFF_W = 5,
  parameter int PFN_W = 7,
  localparam int VA_W = 3 * OFF_W,
  localparam int PA_W = PFN_W + OFF_W,
  localparam int EW   = PFN_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_va,
  input  logic [PFN_W-1:0] req_base,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [1:0]      rsp_fault,
  output logic [EW-1:0]   rsp_data,
  output logic [PA_W-1:0] rsp_pa,
  input  logic            ld_en,
  input  logic [PA_W-1:0] ld_addr,
  input  logic [EW-1:0]   ld_data
);
  walk_st_t        state;
  logic [VA_W-1:0] va_q;
  logic [EW-1:0]   rq;
  logic [PA_W-1:0] rd_addr;

  pw_mem #(.AW(PA_W), .DW(EW)) u_mem (
    .clk(clk), .we(ld_en), .wa(ld_addr), .wd(ld_data),
    .ra(rd_addr), .rq(rq)
  );

  pw_addr #(.OFF_W(OFF_W), .PFN_W(PFN_W)) u_addr (
    .state(state), .req_va(req_va), .req_base(req_base),
    .va_q(va_q), .rq(rq), .rd_addr(rd_addr)
  );

  pw_fsm #(.OFF_W(OFF_W), .PFN_W(PFN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .rsp_ready(rsp_ready), .rq(rq), .state(state), .va_q(va_q),
    .fault_q(rsp_fault), .data_q(rsp_data), .pa_q(rsp_pa)
  );

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_DONE);
endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk #(
  parameter int OFF_W = 5,
  parameter int PFN_W = 7,
  localparam int PA_W = PFN_W + OFF_W,
  localparam int EW   = PFN_W + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [1:0]      rsp_fault,
  input logic [EW-1:0]   rsp_data,
  input logic [PA_W-1:0] rsp_pa
);
  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault)
                                   && $stable(rsp_data) && $stable(rsp_pa)));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (!rsp_valid && req_ready));

  p_fault_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault != 2'b11));

  p_fault_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> (rsp_data == '0 && rsp_pa == '0));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && req_ready));
endmodule

bind pw_walker pw_walker_chk #(.OFF_W(OFF_W), .PFN_W(PFN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
  .rsp_data(rsp_data), .rsp_pa(rsp_pa)
);

// File: tb/pw_walker_bench.sv
module pw_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NBYTES = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [14:0] req_va = '0;
  logic [6:0]  req_base = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [1:0]  rsp_fault;
  logic [7:0]  rsp_data;
  logic [11:0] rsp_pa;
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [7:0] model [NBYTES];

  always #(CLK_PERIOD/2) clk = ~clk;

  pw_walker u_pw_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_base(req_base), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_data(rsp_data),
    .rsp_pa(rsp_pa), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: act %0d cycles exp < 150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act 0x%0h exp 0x%0h", req, what, act, exp);
    end
  endtask

  // reference walk computed from the bench's own copy of memory
  task automatic ref_walk(input logic [14:0] va, input logic [6:0] base,
                          output logic [1:0] f, output logic [7:0] d,
                          output logic [11:0] pa);
    logic [7:0] pde, pte;
    pde = model[int'(base) * 32 + int'(va[14:10])];
    f = 2'b00; d = '0; pa = '0;
    if (!pde[7]) begin
      f = 2'b01;
    end else begin
      pte = model[int'(pde[6:0]) * 32 + int'(va[9:5])];
      if (!pte[7]) f = 2'b10;
      else begin
        pa = {pte[6:0], va[4:0]};
        d  = model[int'(pa)];
      end
    end
  endtask

  task automatic wait_rsp();
    int guard = 0;
    @(negedge clk);
    while (!rsp_valid && guard < 100) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic walk(input logic [14:0] va, input logic [6:0] base,
                      input int hold, input string tag);
    logic [1:0] ef; logic [7:0] ed; logic [11:0] ep;
    logic [1:0] f0; logic [7:0] d0; logic [11:0] p0;
    bit stable_ok;
    ref_walk(va, base, ef, ed, ep);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_base = base;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    req_base = ~base;           // R6: changes after acceptance have no effect
    req_va = ~va;
    @(negedge clk);
    chk(req_ready == 1'b0, "R6", "req_ready while busy", int'(req_ready), 0);
    wait_rsp();
    f0 = rsp_fault; d0 = rsp_data; p0 = rsp_pa;
    stable_ok = 1'b1;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_fault != f0 || rsp_data != d0 || rsp_pa != p0)
        stable_ok = 1'b0;
    end
    if (hold > 0) chk(stable_ok, "R7", "hold under back-pressure", int'(stable_ok), 1);
    chk(rsp_valid == 1'b1, tag, "rsp_valid", int'(rsp_valid), 1);
    chk(rsp_fault == ef, tag, "fault", int'(rsp_fault), int'(ef));
    chk(rsp_data == ed, tag, "data", int'(rsp_data), int'(ed));
    chk(rsp_pa == ep, tag, "pa", int'(rsp_pa), int'(ep));
    rsp_ready = 1'b1;
    @(posedge clk);
    #1;
    rsp_ready = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R7", "idle after handshake",
        int'({req_ready, rsp_valid}), 2);
  endtask

  initial begin
    logic [1:0] ef; logic [7:0] ed; logic [11:0] ep;
    logic [14:0] cva;
    // memory image: filler, directory on page 2, tables on pages 8..39
    for (int a = 0; a < NBYTES; a++) model[a] = 8'((a * 37 + 11) & 255);
    for (int i = 0; i < 32; i++) begin
      model[64 + i] = (i % 4 == 3) ? 8'h15 : {1'b1, 7'(8 + i)};
      for (int j = 0; j < 32; j++)
        model[(8 + i) * 32 + j] = ((i + j) % 5 == 0) ? 8'h00
                                : {1'b1, 7'(40 + ((i * 32 + j) * 7) % 88)};
    end

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "req_ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R9", "rsp_valid after reset", int'(rsp_valid), 0);

    // R8: fill memory through the load port
    for (int a = 0; a < NBYTES; a++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 12'(a); ld_data = model[a];
    end
    @(negedge clk);
    ld_en = 1'b0;

    // R1 R2 R3 R4 R5: every virtual page through directory on page 2
    for (int v = 0; v < 1024; v++) begin
      logic [14:0] va;
      va = {10'(v), 5'((v * 3) % 32)};
      walk(va, 7'd2, (v % 97 == 0) ? 3 : 0, "R1/R2/R3/R4/R5");
    end

    // R2: directory on a filler page, mixed outcomes
    for (int v = 0; v < 64; v++)
      walk(15'((v * 517 + 29) % 32768), 7'd50, 0, "R2");

    // R8: load write and data read of the same byte on the same edge
    cva = {5'd0, 5'd1, 5'd7};
    ref_walk(cva, 7'd2, ef, ed, ep);
    chk(ef == 2'b00, "R8", "collision setup valid", int'(ef), 0);
    @(negedge clk);
    req_valid = 1'b1; req_va = cva; req_base = 7'd2;
    @(posedge clk);             // accept, directory read
    #1 req_valid = 1'b0;
    @(posedge clk);             // table read
    @(negedge clk);
    ld_en = 1'b1; ld_addr = ep; ld_data = ~ed;
    @(posedge clk);             // data read and write together
    #1 ld_en = 1'b0;
    wait_rsp();
    chk(rsp_data == ed, "R8", "collision returns old byte", int'(rsp_data), int'(ed));
    chk(rsp_pa == ep, "R8", "collision pa", int'(rsp_pa), int'(ep));
    rsp_ready = 1'b1;
    @(posedge clk);
    #1 rsp_ready = 1'b0;
    model[int'(ep)] = ~ed;
    walk(cva, 7'd2, 2, "R8");

    finish_run();
  end
endmodule